// File: doc/BRIEF.md
# Packed Halfword Add/Subtract Unit with Flag-Driven Byte Select

This datapath block runs two instruction kinds and keeps a 4-bit greater-or-equal flag register. The add/subtract kind treats each 32-bit operand as two signed 16-bit lanes. It forms a lane sum or difference, or a crossed pair that mixes the low half of one operand with the high half of the other. Lane results wrap to 16 bits and are not saturated. The sign of each full-precision lane result is copied into a pair of flag bits. The select kind builds a 32-bit word one byte at a time. Each byte comes from the first operand when its flag bit is set, and from the second operand when it is clear. The select kind reads the flags and never writes them.

The surrounding pipeline reads the two source registers and supplies them as `opa` (the first source, n) and `opb` (the second source, m), together with the raw instruction word and a condition-pass bit. A two-state sequencer registers every executed instruction. In `ST_IDLE` no write is pending. The transition `accept` (a valid instruction whose condition allows execution) enters `ST_WRITE`. `ST_WRITE` presents the result and destination index with write-enable high for one cycle. The transition `drain` returns to `ST_IDLE` when no new instruction executes. `chain` stays in `ST_WRITE` when one does.

Top module: `pkh_lane_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, the flag nibble is 0000, write-enable is low and the result is zero.
- R2: Add/subtract kind (`kind_sel`=0) with selector instr[7:5]=0 gives low lane n_lo+m_lo and high lane n_hi+m_hi. Each lane wraps to 16 bits with no saturation, and the low lane is result[15:0].
- R3: Selector 1 gives low n_lo−m_hi and high n_hi+m_lo. Selector 2 gives low n_lo+m_hi and high n_hi−m_lo.
- R4: Selector 3 gives low n_lo−m_lo and high n_hi−m_hi, with wrap-around.
- R5: After an executed add/subtract, flag bits 0 and 1 are both 1 when the full-precision signed low-lane result is ≥ 0, and both 0 otherwise.
- R6: After an executed add/subtract, flag bits 2 and 3 follow the same rule for the high-lane result.
- R7: Selectors 4 to 7 on the add/subtract kind give a zero result and set all four flags.
- R8: On the select kind (`kind_sel`=1), result byte k (bits 8k+7:8k) equals byte k of `opa` when flag bit k was set before the instruction, and byte k of `opb` otherwise. The flags are left unchanged.
- R9: An instruction executes when its condition field instr[31:28] is 0xE, or when `cond_pass` is high. Otherwise write-enable stays low and the flags do not change.
- R10: An executed instruction raises `wr_en` for exactly the next cycle. The new result and `dest_idx` = instr[15:12] appear on that cycle, and the flags change on the same edge.
- R11: `status_word` carries the flag nibble at bits 19:16, and all of its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word (condition, selector, destination index) |
| kind_sel | input | 1 | 0 = packed add/subtract, 1 = byte select |
| cond_pass | input | 1 | Condition evaluated true by the pipeline |
| opa | input | 32 | First source operand (n) |
| opb | input | 32 | Second source operand (m) |
| result | output | 32 | Registered result |
| dest_idx | output | 4 | Registered destination register index |
| wr_en | output | 1 | Result write strobe |
| flag_nib | output | 4 | Current greater-or-equal flags |
| status_word | output | 32 | Status view with flags at bits 19:16 |

## Verification
The bench sweeps all eight selectors against every combination of eight halfword corner values. The values include 0x7FFF, 0x8000, 0xFFFF and 0x8001. This pattern catches a design that saturates instead of wrapping, and one that takes the flag sign from the truncated 16-bit lane instead of the full-precision result; for example, 0x7FFF+0x0001 must wrap to 0x8000 yet still set its flags. Each of the four reachable flag patterns is then followed by a select instruction, which exposes a reversed byte order, swapped sources, or a select that clobbers the flags. Condition handling is probed with 0xE and with a non-0xE field with `cond_pass` low and then high. A design that ignored the pass bit would write a result and move the flags when it should not.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
    localparam int WORD_W   = 32;
    localparam int LANE_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = WORD_W / BYTE_W;
    localparam int FLAG_W   = NBYTES;
    localparam int IDX_W    = 4;
    localparam int SEL_W    = 3;
    localparam logic [3:0] COND_ALWAYS = 4'hE;

    typedef enum logic {
        KIND_ADDSUB = 1'b0,
        KIND_SELECT = 1'b1
    } kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;
endpackage

// File: rtl/pkh_lane_alu.sv
module pkh_lane_alu
    import pkh_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int LW = LANE_W
) (
    input  logic [W-1:0]     n_in,
    input  logic [W-1:0]     m_in,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     sum_out,
    output logic [FLAG_W-1:0] ge_new
);
    localparam int XW = LW + 1;   // full-precision lane width
    localparam int DUP = FLAG_W / 2;

    logic signed [XW-1:0] n_lo, n_hi, m_lo, m_hi;
    logic signed [XW-1:0] lo_r, hi_r;

    always_comb begin
        n_lo = {n_in[LW-1],   n_in[LW-1:0]};
        n_hi = {n_in[2*LW-1], n_in[2*LW-1:LW]};
        m_lo = {m_in[LW-1],   m_in[LW-1:0]};
        m_hi = {m_in[2*LW-1], m_in[2*LW-1:LW]};
        case (sel)
            3'd0: begin lo_r = n_lo + m_lo; hi_r = n_hi + m_hi; end
            3'd1: begin lo_r = n_lo - m_hi; hi_r = n_hi + m_lo; end
            3'd2: begin lo_r = n_lo + m_hi; hi_r = n_hi - m_lo; end
            3'd3: begin lo_r = n_lo - m_lo; hi_r = n_hi - m_hi; end
            default: begin lo_r = '0; hi_r = '0; end
        endcase
        sum_out = {hi_r[LW-1:0], lo_r[LW-1:0]};
        ge_new  = {{DUP{~hi_r[XW-1]}}, {DUP{~lo_r[XW-1]}}};
    end
endmodule

// File: rtl/pkh_byte_sel.sv
module pkh_byte_sel
    import pkh_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic [NB*BW-1:0] src_a,
    input  logic [NB*BW-1:0] src_b,
    input  logic [NB-1:0]    pick_a,
    output logic [NB*BW-1:0] sel_out
);
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign sel_out[k*BW +: BW] = pick_a[k] ? src_a[k*BW +: BW] : src_b[k*BW +: BW];
    end
endmodule

// File: rtl/pkh_ctrl.sv
module pkh_ctrl
    import pkh_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  kind_e             kind,
    input  logic [W-1:0]      sum_in,
    input  logic [W-1:0]      sel_in,
    input  logic [FLAG_W-1:0] ge_new,
    input  logic [IDX_W-1:0]  dest_in,
    output logic [W-1:0]      result_q,
    output logic [IDX_W-1:0]  dest_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic              wr_en
);
    wr_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nx = go ? ST_WRITE : ST_IDLE;   // accept
            ST_WRITE: state_nx = go ? ST_WRITE : ST_IDLE;   // chain / drain
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb wr_en = (state == ST_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            dest_q   <= '0;
            flags_q  <= '0;
        end else if (go) begin
            dest_q   <= dest_in;
            result_q <= (kind == KIND_SELECT) ? sel_in : sum_in;
            if (kind == KIND_ADDSUB) flags_q <= ge_new;
        end
    end

    p_select_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && kind == KIND_SELECT) |=> $stable(flags_q));
    p_write_follows_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> wr_en);
    p_no_write_without_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !wr_en);
    p_flag_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] == flags_q[1]) && (flags_q[2] == flags_q[3]));
endmodule

// File: rtl/pkh_lane_unit.sv
module pkh_lane_unit
    import pkh_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      instr,
    input  logic              kind_sel,
    input  logic              cond_pass,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    output logic [W-1:0]      result,
    output logic [IDX_W-1:0]  dest_idx,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flag_nib,
    output logic [W-1:0]      status_word
);
    localparam int FLAG_LSB = 16;

    logic              cond_ok, go;
    logic [W-1:0]      sum_w, sel_w;
    logic [FLAG_W-1:0] ge_w;

    assign cond_ok = (instr[31:28] == COND_ALWAYS) || cond_pass;
    assign go      = in_valid && cond_ok;

    pkh_lane_alu #(.W(W), .LW(LANE_W)) u_alu (
        .n_in(opa), .m_in(opb), .sel(instr[7:5]),
        .sum_out(sum_w), .ge_new(ge_w)
    );

    pkh_byte_sel #(.NB(NBYTES), .BW(BYTE_W)) u_sel (
        .src_a(opa), .src_b(opb), .pick_a(flag_nib), .sel_out(sel_w)
    );

    pkh_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind_e'(kind_sel)),
        .sum_in(sum_w), .sel_in(sel_w), .ge_new(ge_w),
        .dest_in(instr[15:12]),
        .result_q(result), .dest_q(dest_idx), .flags_q(flag_nib), .wr_en(wr_en)
    );

    always_comb begin
        status_word = '0;
        status_word[FLAG_LSB +: FLAG_W] = flag_nib;
    end

    p_skip_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] != COND_ALWAYS && !cond_pass) |=> (!wr_en && $stable(flag_nib)));
    p_idle_holds_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flag_nib));
    p_status_view_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[19:16] == flag_nib && status_word[15:0] == '0 && status_word[31:20] == '0);
endmodule

// File: tb/tb_pkh_lane_unit.sv
module tb_pkh_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic        kind_sel;
    logic        cond_pass;
    logic [31:0] opa, opb;
    logic [31:0] result;
    logic [3:0]  dest_idx;
    logic        wr_en;
    logic [3:0]  flag_nib;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_flags = 4'h0;

    always #5 clk = ~clk;

    pkh_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .kind_sel(kind_sel), .cond_pass(cond_pass), .opa(opa), .opb(opb),
        .result(result), .dest_idx(dest_idx), .wr_en(wr_en),
        .flag_nib(flag_nib), .status_word(status_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] cond, input logic kind, input logic cp,
                         input logic [2:0] sel, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] d);
        @(negedge clk);
        instr        = 32'h0060_0000;
        instr[31:28] = cond;
        instr[19:16] = 4'h3;
        instr[15:12] = d;
        instr[7:5]   = sel;
        instr[3:0]   = 4'h9;
        kind_sel  = kind;
        cond_pass = cp;
        opa = a;
        opb = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic void model_add(input logic [2:0] sel, input logic [31:0] a,
                                      input logic [31:0] b, output logic [31:0] res,
                                      output logic [3:0] flg);
        int nl, nh, ml, mh, lo, hi;
        logic [31:0] lo_v, hi_v;
        nl = int'($signed(a[15:0]));  nh = int'($signed(a[31:16]));
        ml = int'($signed(b[15:0]));  mh = int'($signed(b[31:16]));
        case (sel)
            3'd0: begin lo = nl + ml; hi = nh + mh; end
            3'd1: begin lo = nl - mh; hi = nh + ml; end
            3'd2: begin lo = nl + mh; hi = nh - ml; end
            3'd3: begin lo = nl - ml; hi = nh - mh; end
            default: begin lo = 0; hi = 0; end
        endcase
        lo_v = lo;
        hi_v = hi;
        res = {hi_v[15:0], lo_v[15:0]};
        flg = {{2{hi >= 0}}, {2{lo >= 0}}};
    endfunction

    function automatic logic [31:0] model_sel(input logic [3:0] f, input logic [31:0] a,
                                              input logic [31:0] b);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = f[k] ? a[k*8 +: 8] : b[k*8 +: 8];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] hv [8];
        logic [31:0] er;
        logic [3:0]  ef;
        logic [31:0] sa, sb;
        logic [31:0] fset [4];
        hv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h8001, 16'h7FFE};
        rst_n = 1'b0; in_valid = 1'b0; instr = '0; kind_sel = 1'b0;
        cond_pass = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        check("R1 flags in reset", {28'd0, flag_nib}, 32'h0);
        check("R1 wr_en in reset", {31'd0, wr_en}, 32'h0);
        check("R1 result in reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {28'd0, flag_nib}, 32'h0);
        check("R1 wr_en after reset", {31'd0, wr_en}, 32'h0);
        check("R11 status after reset", status_word, 32'h0);

        // R8: select with flags 0000 takes every byte from opb
        issue(4'hE, 1'b1, 1'b0, 3'd0, 32'hAABBCCDD, 32'h11223344, 4'h5);
        check("R8 select all-clear flags", result, 32'h11223344);

        // R2 R3 R4 R5 R6 R7 R10 sweep
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++)
                        for (int l = 0; l < 8; l++) begin
                            logic [3:0] d;
                            d = 4'(i + l);
                            sa = {hv[j], hv[i]};
                            sb = {hv[l], hv[k]};
                            model_add(3'(s), sa, sb, er, ef);
                            issue(4'hE, 1'b0, 1'b0, 3'(s), sa, sb, d);
                            if (s == 0)      check("R2 add result", result, er);
                            else if (s < 3)  check("R3 cross result", result, er);
                            else if (s == 3) check("R4 sub result", result, er);
                            else             check("R7 zero result", result, 32'h0);
                            check("R5 low flags", {30'd0, flag_nib[1:0]}, {30'd0, ef[1:0]});
                            check("R6 high flags", {30'd0, flag_nib[3:2]}, {30'd0, ef[3:2]});
                            check("R10 wr_en and dest", {27'd0, wr_en, dest_idx}, {27'd0, 1'b1, d});
                            check("R11 status view", status_word, {12'd0, ef, 16'd0});
                            exp_flags = ef;
                        end
        check("R7 flags all set", {28'd0, flag_nib}, 32'hF);

        // R8 over every reachable flag pattern
        fset = '{32'h8000_8000, 32'h8000_0000, 32'h0000_8000, 32'h0000_0000};
        for (int p = 0; p < 4; p++) begin
            model_add(3'd0, fset[p], 32'h0, er, ef);
            issue(4'hE, 1'b0, 1'b0, 3'd0, fset[p], 32'h0, 4'h1);
            check("R5 R6 set pattern", {28'd0, flag_nib}, {28'd0, ef});
            issue(4'hE, 1'b1, 1'b0, 3'd0, 32'hAABBCCDD, 32'h11223344, 4'h7);
            check("R8 select bytes", result, model_sel(ef, 32'hAABBCCDD, 32'h11223344));
            check("R8 select keeps flags", {28'd0, flag_nib}, {28'd0, ef});
            issue(4'hE, 1'b1, 1'b0, 3'd0, 32'h01020304, 32'hF0E0D0C0, 4'h7);
            check("R8 select bytes second", result, model_sel(ef, 32'h01020304, 32'hF0E0D0C0));
            exp_flags = ef;
        end

        // R9: condition handling; flags are 1111 here
        issue(4'h0, 1'b0, 1'b0, 3'd0, 32'h8000_8000, 32'h0, 4'h2);
        check("R9 skipped no write", {31'd0, wr_en}, 32'h0);
        check("R9 skipped flags held", {28'd0, flag_nib}, {28'd0, exp_flags});
        issue(4'h0, 1'b0, 1'b1, 3'd0, 32'h8000_8000, 32'h0, 4'h2);
        check("R9 pass executes", {31'd0, wr_en}, 32'h1);
        check("R9 pass flags", {28'd0, flag_nib}, 32'h0);
        issue(4'hE, 1'b0, 1'b0, 3'd3, 32'h0000_0005, 32'h0001_0002, 4'hC);
        check("R9 always cond result", result, 32'hFFFF_0003);
        check("R9 always cond flags", {28'd0, flag_nib}, 32'h3);
        @(negedge clk);
        check("R10 wr_en one cycle", {31'd0, wr_en}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule